// File: doc/BRIEF.md
# Multiplexed ADC Scan Controller

This block is the control and status core of a 64-input acquisition front end. A host reaches it through a small register bus with 16-bit data, where most registers use only the low byte. The host programs a channel window, chooses what starts a conversion, and chooses which event raises the conversion interrupt. On every accepted trigger the controller hands the current channel to a converter model and moves the scan position to the next channel, wrapping at the top of the window. The converter returns a 12-bit result a fixed number of clocks later. The result goes into a sample FIFO, and the host drains the FIFO by reading the data address.

The converter model builds each result from the channel and a running conversion index, so every sample can be traced back to its conversion. The trigger source can be a bus write, either edge of an external trigger line, or a pacer pulse. Status flags report the FIFO level, pending interrupt causes and the pacer clock choice. The interrupt output combines the pending causes with an enable bit.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the channel register reads 0x0000, a data read returns 0x0000, mux_sel is 0 and irq_out is low.
- R2: The channel register is at address 1. Bits 5:0 hold the first channel and bits 13:8 hold the last channel, and both read back there. Writing the register moves the scan position to the first channel.
- R3: Each accepted trigger converts the current channel and then advances the scan position by one. After the last channel it returns to the first. mux_sel shows the channel being converted. The sample enters the FIFO 4 clock edges after the edge that accepted the trigger. A data read at address 0 returns {channel[5:0], index[5:0], 4'b0000}, where index counts accepted conversions modulo 64 from reset.
- R4: Control bits 1:0 at address 3 select the trigger source. 0 means any write to address 0. 1 means a falling edge on ext_trig_in. 2 means a rising edge on ext_trig_in. 3 means a pulse on pacer_tick. Triggers from any other source, and triggers that arrive while a conversion is in progress, start nothing.
- R5: Writing source 0 to the control register stops paced acquisition, so later pacer pulses add no samples.
- R6: Status at address 2 has these bits. Bit 0 means the FIFO is not empty. Bit 1 means it holds at least 512 entries. Bit 2 means it holds 1024 entries.
- R7: A sample that completes while the FIFO is full is dropped. The full flag stays set until a data read removes the oldest entry.
- R8: A data read from an empty FIFO returns the value of the previous successful read and leaves the FIFO empty.
- R9: Mode bits 3:2 at address 4 choose when status bit 4 (conversion interrupt) is set. 0 means never. 1 means on every completed conversion. 2 means on a completed conversion that leaves at least 512 entries in the FIFO. 3 means on completion of the last channel of the window.
- R10: A status write clears the conversion interrupt with bit 0, the external-trigger flag with bit 1 and the external-interrupt flag with bit 2. A zero in any of these bits leaves that flag unchanged. Bit 7 of the write is stored and reads back as status bit 7.
- R11: Status bit 5 is set by an edge of ext_trig_in that matches the selected external source 1 or 2. Status bit 3 is set by a rising edge of ext_irq_in.
- R12: irq_out is high exactly when control bit 7 is set and status bit 4 or status bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; at address 0 pops one FIFO entry |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, valid in the same cycle |
| ext_trig_in | input | 1 | External trigger line, synchronous to clk |
| ext_irq_in | input | 1 | External interrupt line, synchronous to clk |
| pacer_tick | input | 1 | One-cycle pacer pulse |
| mux_sel | output | 6 | Channel of the current or most recent conversion |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions assume that ext_trig_in, ext_irq_in and pacer_tick are already synchronous to clk. They also assume that a bus access lasts one cycle, with read and write never asserted together. The stimulus drives every input one time unit after the falling edge and holds each strobe for exactly one cycle. It keeps pacer pulses and software triggers further apart than the conversion latency, except in the one case that checks a trigger arriving while a conversion is busy. It never writes the channel register in the same cycle as a trigger, where the choice of scan position would depend on priority.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    TRG_SW   = 2'd0,
    TRG_FALL = 2'd1,
    TRG_RISE = 2'd2,
    TRG_PACE = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    ICOND_NONE     = 2'd0,
    ICOND_NEMPTY   = 2'd1,
    ICOND_HALF     = 2'd2,
    ICOND_SCAN_END = 2'd3
  } icond_e;

  localparam logic [2:0] ADR_DATA = 3'd0;
  localparam logic [2:0] ADR_MUX  = 3'd1;
  localparam logic [2:0] ADR_STAT = 3'd2;
  localparam logic [2:0] ADR_CTRL = 3'd3;
  localparam logic [2:0] ADR_MODE = 3'd4;

endpackage

// File: rtl/scan_fifo.sv
module scan_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            head,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     empty,
  output logic                     full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign level   = cnt_q;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    if (push_ok) wr_n = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_n = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
    cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  // R7: the level never exceeds the depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7: full is held until a pop happens
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

  // R8: popping an empty FIFO leaves it empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

endmodule

// File: rtl/conv_model.sv
module conv_model #(
  parameter int CH_W  = 6,
  parameter int SEQ_W = 6,
  parameter int LAT   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CH_W-1:0]        chan_in,
  output logic                   busy,
  output logic                   done,
  output logic [CH_W-1:0]        chan_q,
  output logic [CH_W+SEQ_W-1:0]  sample
);
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CH_W-1:0]  chan_n;
  logic [SEQ_W-1:0] seq_q, seq_n, sseq_q, sseq_n;
  logic             accept;

  assign accept = start && !busy_q;
  assign done   = busy_q && (cnt_q == '0);
  assign busy   = busy_q;
  assign sample = {chan_q, sseq_q};

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    chan_n = chan_q;
    seq_n  = seq_q;
    sseq_n = sseq_q;
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = CNT_LOAD;
      chan_n = chan_in;
      sseq_n = seq_q;
      seq_n  = seq_q + 1'b1;
    end else if (done) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      chan_q <= '0;
      seq_q  <= '0;
      sseq_q <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      chan_q <= chan_n;
      seq_q  <= seq_n;
      sseq_q <= sseq_n;
    end
  end

  // R4: a conversion in progress is never abandoned before it completes
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);

  // R3: completion frees the converter for at least one cycle
  p_done_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

endmodule

// File: rtl/trig_select.sv
module trig_select
  import adc_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trig_src_e src,
  input  logic      sw_hit,
  input  logic      ext_in,
  input  logic      tick,
  output logic      trig,
  output logic      ext_edge
);
  logic prev_q;
  logic rise, fall;

  assign rise = ext_in && !prev_q;
  assign fall = !ext_in && prev_q;

  always_comb begin
    ext_edge = 1'b0;
    trig     = 1'b0;
    unique case (src)
      TRG_SW:   trig = sw_hit;
      TRG_FALL: begin ext_edge = fall; trig = fall; end
      TRG_RISE: begin ext_edge = rise; trig = rise; end
      TRG_PACE: trig = tick;
      default:  trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ext_in;
  end

  // R5: with the software source selected only a data write can trigger
  p_sw_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == TRG_SW && !sw_hit) |-> !trig);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CH_W   = 6,
  parameter int SEQ_W  = 6,
  parameter int DEPTH  = 1024,
  parameter int LAT    = 4,
  parameter int BUS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             ext_trig_in,
  input  logic             ext_irq_in,
  input  logic             pacer_tick,
  output logic [5:0]       mux_sel,
  output logic             irq_out
);
  localparam int SMP_W = CH_W + SEQ_W;
  localparam int PAD   = BUS_W - SMP_W;
  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam int HI_LSB = 8;
  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

  // bus decode
  logic wr_data, wr_mux, wr_stat, wr_ctrl, wr_mode, rd_data;
  assign wr_data = bus_wr && (bus_addr == ADR_DATA);
  assign wr_mux  = bus_wr && (bus_addr == ADR_MUX);
  assign wr_stat = bus_wr && (bus_addr == ADR_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_mode = bus_wr && (bus_addr == ADR_MODE);
  assign rd_data = bus_rd && (bus_addr == ADR_DATA);

  // registers
  logic [CH_W-1:0]  first_q, first_n, last_q, last_n, cur_q, cur_n;
  trig_src_e        src_q, src_n;
  logic             inte_q, inte_n;
  icond_e           icond_q, icond_n;
  logic             fast_q, fast_n;
  logic             ipend_q, ipend_n;
  logic             xtrig_q, xtrig_n;
  logic             xint_q, xint_n;
  logic             irqin_prev_q;
  logic [SMP_W-1:0] lastrd_q, lastrd_n;

  // sub-block nets
  logic             trig, ext_edge;
  logic             conv_busy, conv_done, conv_go;
  logic [CH_W-1:0]  conv_chan;
  logic [SMP_W-1:0] conv_sample, fifo_head;
  logic [LVL_W-1:0] fifo_level, lvl_after;
  logic             fifo_empty, fifo_full, push_ok, pop_ok, half;
  logic             pend_set, xint_rise;

  trig_select u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src_q),
    .sw_hit   (wr_data),
    .ext_in   (ext_trig_in),
    .tick     (pacer_tick),
    .trig     (trig),
    .ext_edge (ext_edge)
  );

  assign conv_go = trig && !conv_busy;

  conv_model #(.CH_W(CH_W), .SEQ_W(SEQ_W), .LAT(LAT)) u_conv (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (trig),
    .chan_in (cur_q),
    .busy    (conv_busy),
    .done    (conv_done),
    .chan_q  (conv_chan),
    .sample  (conv_sample)
  );

  scan_fifo #(.DW(SMP_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (conv_done),
    .pop   (rd_data),
    .wdata (conv_sample),
    .head  (fifo_head),
    .level (fifo_level),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign push_ok   = conv_done && !fifo_full;
  assign pop_ok    = rd_data && !fifo_empty;
  assign lvl_after = fifo_level + LVL_W'(push_ok) - LVL_W'(pop_ok);
  assign half      = (fifo_level >= HALF_LVL);
  assign xint_rise = ext_irq_in && !irqin_prev_q;

  always_comb begin
    unique case (icond_q)
      ICOND_NEMPTY:   pend_set = conv_done;
      ICOND_HALF:     pend_set = conv_done && (lvl_after >= HALF_LVL);
      ICOND_SCAN_END: pend_set = conv_done && (conv_chan == last_q);
      default:        pend_set = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    first_n  = first_q;
    last_n   = last_q;
    cur_n    = cur_q;
    src_n    = src_q;
    inte_n   = inte_q;
    icond_n  = icond_q;
    fast_n   = fast_q;
    lastrd_n = lastrd_q;
    if (wr_mux) begin
      first_n = bus_wdata[CH_W-1:0];
      last_n  = bus_wdata[HI_LSB+CH_W-1:HI_LSB];
      cur_n   = bus_wdata[CH_W-1:0];
    end else if (conv_go) begin
      cur_n = (cur_q == last_q) ? first_q : cur_q + 1'b1;
    end
    if (wr_ctrl) begin
      src_n  = trig_src_e'(bus_wdata[1:0]);
      inte_n = bus_wdata[7];
    end
    if (wr_mode) icond_n = icond_e'(bus_wdata[3:2]);
    if (wr_stat) fast_n = bus_wdata[7];
    if (pop_ok)  lastrd_n = fifo_head;
    ipend_n = (ipend_q && !(wr_stat && bus_wdata[0])) || pend_set;
    xtrig_n = (xtrig_q && !(wr_stat && bus_wdata[1])) || ext_edge;
    xint_n  = (xint_q  && !(wr_stat && bus_wdata[2])) || xint_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q      <= '0;
      last_q       <= '0;
      cur_q        <= '0;
      src_q        <= TRG_SW;
      inte_q       <= 1'b0;
      icond_q      <= ICOND_NONE;
      fast_q       <= 1'b0;
      ipend_q      <= 1'b0;
      xtrig_q      <= 1'b0;
      xint_q       <= 1'b0;
      irqin_prev_q <= 1'b0;
      lastrd_q     <= '0;
    end else begin
      first_q      <= first_n;
      last_q       <= last_n;
      cur_q        <= cur_n;
      src_q        <= src_n;
      inte_q       <= inte_n;
      icond_q      <= icond_n;
      fast_q       <= fast_n;
      ipend_q      <= ipend_n;
      xtrig_q      <= xtrig_n;
      xint_q       <= xint_n;
      irqin_prev_q <= ext_irq_in;
      lastrd_q     <= lastrd_n;
    end
  end

  // read path
  logic [SMP_W-1:0] data_word;
  logic [15:0]      data_bus;
  logic [7:0]       stat_byte;

  assign data_word = fifo_empty ? lastrd_q : fifo_head;

  generate
    if (PAD > 0) begin : g_left_just
      assign data_bus = {data_word, {PAD{1'b0}}};
    end else begin : g_full_width
      assign data_bus = data_word[SMP_W-1:SMP_W-16];
    end
  endgenerate

  assign stat_byte = {fast_q, 1'b0, xtrig_q, ipend_q, xint_q,
                      fifo_full, half, !fifo_empty};

  always_comb begin
    unique case (bus_addr)
      ADR_DATA: bus_rdata = data_bus;
      ADR_MUX:  bus_rdata = {2'b00, last_q, 2'b00, first_q};
      ADR_STAT: bus_rdata = {8'h00, stat_byte};
      ADR_CTRL: bus_rdata = {8'h00, inte_q, 5'b00000, src_q};
      ADR_MODE: bus_rdata = {12'h000, icond_q, 2'b00};
      default:  bus_rdata = 16'h0000;
    endcase
  end

  assign mux_sel = conv_chan;
  assign irq_out = inte_q && (ipend_q || xint_q);

  logic unused_wbits;
  assign unused_wbits = &{bus_wdata[15:14], bus_wdata[6:4], 1'b1};

  // R3: a conversion starts on the channel the scan position pointed at
  p_scan_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> (mux_sel == $past(cur_q)));

  // R9: the conversion interrupt only rises under a selected condition
  p_pend_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ipend_q && (icond_q == ICOND_NONE)) |=> !ipend_q);

  // R10: a clear strobe with no new cause drops the pending flag
  p_clear_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !conv_done) |=> !ipend_q);

  // R11: a rising edge on the external interrupt line is always captured
  p_xint_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq_in && !irqin_prev_q) |=> xint_q);

  // R12: a disabled interrupt output stays low
  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!inte_q && !wr_ctrl) |=> !irq_out);

endmodule

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;
  localparam int DEPTH = 1024;
  localparam int LAT   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        ext_trig_in = 1'b0;
  logic        ext_irq_in = 1'b0;
  logic        pacer_tick = 1'b0;
  logic [5:0]  mux_sel;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  adc_scan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig_in(ext_trig_in), .ext_irq_in(ext_irq_in),
    .pacer_tick(pacer_tick), .mux_sel(mux_sel), .irq_out(irq_out)
  );

  // ---------------- reference model ----------------
  int q[$];
  int m_last, m_first, m_lch, m_cur, m_src, m_inte, m_icond, m_fast;
  int m_ip, m_xt, m_xi, m_busy, m_cnt, m_cch, m_ssq, m_seq, m_eprev, m_iprev;

  function automatic int smp(int ch, int sq);
    return ((ch << 6) | (sq & 63)) << 4;
  endfunction

  function automatic int m_stat();
    int s;
    s = (m_fast << 7) | (m_xt << 5) | (m_ip << 4) | (m_xi << 3);
    if (q.size() == DEPTH) s |= 4;
    if (q.size() >= DEPTH/2) s |= 2;
    if (q.size() > 0) s |= 1;
    return s;
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return (q.size() > 0) ? q[0] : m_last;
      1: return (m_lch << 8) | m_first;
      2: return m_stat();
      3: return (m_inte << 7) | m_src;
      4: return m_icond << 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_last = 0; m_first = 0; m_lch = 0; m_cur = 0; m_src = 0; m_inte = 0;
      m_icond = 0; m_fast = 0; m_ip = 0; m_xt = 0; m_xi = 0; m_busy = 0;
      m_cnt = 0; m_cch = 0; m_ssq = 0; m_seq = 0; m_eprev = 0; m_iprev = 0;
    end else begin
      int a, d, rise, fall, trig, xedge, dn, pre, after, setp, stw, acc;
      a = bus_addr; d = bus_wdata;
      rise = ext_trig_in && !m_eprev;
      fall = !ext_trig_in && m_eprev;
      xedge = (m_src == 1 && fall) || (m_src == 2 && rise);
      trig = (m_src == 0 && bus_wr && a == 0) || xedge || (m_src == 3 && pacer_tick);
      dn = m_busy && m_cnt == 0;
      pre = q.size();
      if (bus_rd && a == 0 && pre > 0) m_last = q.pop_front();
      if (dn && pre < DEPTH) q.push_back(smp(m_cch, m_ssq));
      after = q.size();
      setp = dn && (m_icond == 1 || (m_icond == 2 && after >= DEPTH/2) ||
                    (m_icond == 3 && m_cch == m_lch));
      stw = bus_wr && a == 2;
      m_ip = (m_ip && !(stw && d[0])) || setp;
      m_xt = (m_xt && !(stw && d[1])) || xedge;
      m_xi = (m_xi && !(stw && d[2])) || (ext_irq_in && !m_iprev);
      if (stw) m_fast = d[7];
      acc = trig && !m_busy;
      if (acc) begin
        m_busy = 1; m_cnt = LAT - 1; m_cch = m_cur; m_ssq = m_seq;
        m_seq = (m_seq + 1) % 64;
        m_cur = (m_cur == m_lch) ? m_first : (m_cur + 1) % 64;
      end else if (dn) m_busy = 0;
      else if (m_busy) m_cnt--;
      if (bus_wr && a == 1) begin
        m_first = d & 63; m_lch = (d >> 8) & 63; m_cur = m_first;
      end
      if (bus_wr && a == 3) begin m_src = d & 3; m_inte = (d >> 7) & 1; end
      if (bus_wr && a == 4) m_icond = (d >> 2) & 3;
      m_eprev = ext_trig_in; m_iprev = ext_irq_in;
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      int er;
      string tg;
      er = m_read(bus_addr);
      tg = (bus_addr == 0) ? "R3" : (bus_addr == 1) ? "R2" :
           (bus_addr == 2) ? "R6" : (bus_addr == 3) ? "R4" : "R9";
      checks++;
      if (bus_rdata !== 16'(er)) begin
        failures++;
        $display("FAIL %s model rdata addr=%0d act=%h exp=%h", tg, bus_addr, bus_rdata, 16'(er));
      end
      checks++;
      if (irq_out !== (m_inte && (m_ip || m_xi))) begin
        failures++;
        $display("FAIL R12 model irq act=%b exp=%b", irq_out, (m_inte && (m_ip || m_xi)));
      end
      checks++;
      if (mux_sel !== 6'(m_cch)) begin
        failures++;
        $display("FAIL R3 model mux_sel act=%0d exp=%0d", mux_sel, m_cch);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(int a, int d);
    @(negedge clk); #1;
    bus_addr = 3'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic brd(int a, output int v);
    @(negedge clk); #1;
    bus_addr = 3'(a); bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic peek(int a, output int v);
    @(negedge clk); #1;
    bus_addr = 3'(a);
    #1 v = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); #1 pacer_tick = 1'b1;
    @(negedge clk); #1 pacer_tick = 1'b0;
    idle(4);
  endtask

  task automatic summary();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int v, n;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    peek(2, v); chk(v == 0, "R1 status after reset", v, 0);
    peek(1, v); chk(v == 0, "R1 mux after reset", v, 0);
    peek(0, v); chk(v == 0, "R1 data after reset", v, 0);
    chk(irq_out == 0 && mux_sel == 0, "R1 irq/mux_sel after reset", {irq_out, mux_sel}, 0);

    // R2 channel register
    bwr(1, 16'h0503);
    peek(1, v); chk(v == 16'h0503, "R2 mux readback", v, 16'h0503);

    // R3 software scan with wrap
    bwr(0, 0); idle(8);
    chk(mux_sel == 3, "R3 mux_sel first channel", mux_sel, 3);
    bwr(0, 0); idle(8);
    bwr(0, 0); idle(8);
    bwr(0, 0); idle(8);
    brd(0, v); chk(v == smp(3, 0), "R3 sample ch3", v, smp(3, 0));
    brd(0, v); chk(v == smp(4, 1), "R3 sample ch4", v, smp(4, 1));
    brd(0, v); chk(v == smp(5, 2), "R3 sample ch5", v, smp(5, 2));
    brd(0, v); chk(v == smp(3, 3), "R3 sample wrap to ch3", v, smp(3, 3));

    // R8 empty read
    brd(0, v); chk(v == smp(3, 3), "R8 empty read repeats last", v, smp(3, 3));
    peek(2, v); chk((v & 1) == 0, "R8 still empty", v & 1, 0);

    // R4 trigger while busy is ignored
    bwr(0, 0); bwr(0, 0); idle(8);
    brd(0, v); chk(v == smp(4, 4), "R4 one conversion only", v, smp(4, 4));
    peek(2, v); chk((v & 1) == 0, "R4 busy trigger dropped", v & 1, 0);

    // R4/R11 rising-edge source
    bwr(3, 2);
    @(negedge clk); #1 ext_trig_in = 1'b1; idle(8);
    @(negedge clk); #1 ext_trig_in = 1'b0; idle(8);
    peek(2, v); chk((v & 8'h21) == 8'h21, "R11 ext trig flag and one sample", v & 8'h21, 8'h21);
    brd(0, v); chk(v == smp(5, 5), "R4 rising edge sample", v, smp(5, 5));
    peek(2, v); chk((v & 1) == 0, "R4 falling edge ignored in rising mode", v & 1, 0);
    bwr(2, 16'h02);
    peek(2, v); chk((v & 8'h20) == 0, "R10 clear ext trig flag", v & 8'h20, 0);

    // R4 falling-edge source
    bwr(3, 1);
    @(negedge clk); #1 ext_trig_in = 1'b1; idle(8);
    peek(2, v); chk((v & 1) == 0, "R4 rising edge ignored in falling mode", v & 1, 0);
    @(negedge clk); #1 ext_trig_in = 1'b0; idle(8);
    brd(0, v); chk(v == smp(3, 6), "R4 falling edge sample", v, smp(3, 6));

    // R11/R10/R12 external interrupt and masking
    @(negedge clk); #1 ext_irq_in = 1'b1; idle(2);
    @(negedge clk); #1 ext_irq_in = 1'b0;
    peek(2, v); chk((v & 8'h28) == 8'h28, "R11 ext irq flag", v & 8'h28, 8'h28);
    chk(irq_out == 0, "R12 masked irq", irq_out, 0);
    bwr(2, 16'h81);
    peek(2, v); chk((v & 8'hA8) == 8'hA8, "R10 zero bits keep flags, bit7 stored", v & 8'hA8, 8'hA8);
    bwr(3, 16'h80);
    chk(irq_out == 1, "R12 enabled irq", irq_out, 1);
    bwr(2, 16'h84);
    chk(irq_out == 0, "R12 irq drops after clear", irq_out, 0);

    // R9 end-of-window condition then per-sample condition
    bwr(4, 16'h0C);
    bwr(1, 16'h0100);
    bwr(0, 0); idle(8);
    peek(2, v); chk((v & 16) == 0, "R9 no pend before last channel", v & 16, 0);
    bwr(0, 0); idle(8);
    peek(2, v); chk((v & 16) == 16, "R9 pend at last channel", v & 16, 16);
    chk(irq_out == 1, "R12 irq from conversion pend", irq_out, 1);
    bwr(2, 16'h81);
    peek(2, v); chk((v & 16) == 0, "R10 clear conversion pend", v & 16, 0);
    bwr(4, 16'h04);
    bwr(0, 0); idle(8);
    peek(2, v); chk((v & 16) == 16, "R9 pend on every sample", v & 16, 16);
    bwr(2, 16'h81);
    bwr(4, 16'h00);
    bwr(0, 0); idle(8);
    peek(2, v); chk((v & 16) == 0, "R9 polled mode never pends", v & 16, 0);
    for (int i = 0; i < 4; i++) brd(0, v);

    // R5 pacer then stop
    bwr(3, 3);
    for (int i = 0; i < 5; i++) tick();
    bwr(3, 0);
    for (int i = 0; i < 5; i++) tick();
    n = 0;
    peek(2, v);
    while ((v & 1) && n < 20) begin brd(0, v); n++; peek(2, v); end
    chk(n == 5, "R5 pacer stopped", n, 5);

    // R6/R7 fill to half and full with half condition
    bwr(4, 16'h08);
    bwr(3, 3);
    for (int i = 0; i < DEPTH + 6; i++) begin
      tick();
      if (i == DEPTH/2 - 2) begin
        peek(2, v); chk((v & 16'h12) == 0, "R6 below half", v & 16'h12, 0);
      end
      if (i == DEPTH/2 - 1) begin
        peek(2, v); chk((v & 16'h12) == 16'h12, "R6/R9 half reached", v & 16'h12, 16'h12);
      end
    end
    bwr(3, 0);
    peek(2, v); chk((v & 7) == 7, "R6 full flag", v & 7, 7);
    idle(10);
    peek(2, v); chk((v & 4) == 4, "R7 full held", v & 4, 4);
    brd(0, v);
    peek(2, v); chk((v & 4) == 0, "R7 full clears after read", v & 4, 0);
    n = 1;
    while ((v & 1) && n < DEPTH + 10) begin brd(0, v); n++; peek(2, v); end
    chk(n == DEPTH, "R7 extra samples dropped", n, DEPTH);

    idle(4);
    summary();
    $finish;
  end
endmodule